// File: doc/BRIEF.md
# Retirement Stall Cycle Accounter

This block watches the retirement stream of an in-order core that can issue two instructions side by side, and keeps a running account of where the cycles went. For each retiring instruction it takes the base cycle count, up to two source register indices with valid flags, a load flag with its destination register, and a branch flag with its taken outcome. It works out how many cycles that instruction lost to a load-use hazard and to a taken branch, and adds them to a set of running counters.

Load-use hazards are found with two 16-bit register masks. A load marks its destination in a pending mask. After every instruction the pending mask becomes the active mask that later sources are compared against. The pending mask is emptied at the first member of each issue group. Instructions issued as a pair are charged, in the total cycle counter, the larger of the two members' costs. The stall counters still receive every member's own stalls.

All counters are plain parallel outputs that software or a trace unit can sample. The block does not control the pipeline.

Top module: `stall_cycle_accounter`

## Requirements
- R1: A synchronous active-low reset clears every counter, the per-instruction cycle output and both register masks. After reset, no source can see a hazard left by a load retired before the reset.
- R2: A valid source whose register index is set in the active mask costs 2 stall cycles. Each source is counted separately, so two matching sources cost 4. This holds even when both sources name the same register.
- R3: A source whose valid flag is low never causes a stall, whatever its index.
- R4: A retiring branch that is taken adds 2 to the branch-stall counter and 1 to the taken counter. A branch that is not taken adds 1 to the untaken counter only. An instruction with the branch flag low changes none of the three.
- R5: One clock after an instruction retires, `instr_cycles` shows its base cycles plus its load stall plus its branch stall.
- R6: The total cycle counter changes only when a member flagged as the last of its group retires. It then grows by the largest `instr_cycles` value among the members of that group. A single instruction is a group with both the first and last flags high.
- R7: The load-stall and branch-stall counters add the stalls of every retiring member, including members that did not set the group maximum.
- R8: After each instruction the active mask takes the value of the pending mask. The pending mask is cleared when a first member retires, before that member's load is recorded. As a result, a load stalls the later members of its own group and the first instruction of the next group, and no later instruction.
- R9: Every counter saturates at its all-ones value and never wraps.
- R10: While no instruction retires, all counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| grp_first | input | 1 | The retiring instruction opens its issue group |
| grp_last | input | 1 | The retiring instruction closes its issue group |
| base_cycles | input | CYC_W (8) | Base cycle cost of the instruction |
| src_a_vld | input | 1 | First source index is meaningful |
| src_a_idx | input | 4 | First source register index |
| src_b_vld | input | 1 | Second source index is meaningful |
| src_b_idx | input | 4 | Second source register index |
| is_load | input | 1 | The instruction is a load |
| load_dst | input | 4 | Destination register of the load |
| is_branch | input | 1 | The instruction is a control transfer |
| br_taken | input | 1 | The control transfer was taken |
| instr_cycles | output | CYC_W+3 (11) | Cost of the last retired instruction |
| total_cycles | output | CNT_W (32) | Accumulated cycles, pair maximum applied |
| load_stall_cycles | output | CNT_W (32) | Accumulated load-use stall cycles |
| branch_stall_cycles | output | CNT_W (32) | Accumulated taken-branch stall cycles |
| taken_branches | output | CNT_W (32) | Number of taken branches |
| untaken_branches | output | CNT_W (32) | Number of branches not taken |

## Verification
The assertions assume that at most one instruction retires per clock and that issue groups arrive well formed: every group opens with a first member and closes with a last member, and groups do not interleave. They also assume that `br_taken` has meaning only while `is_branch` is high. The stimulus drives only singles and first/last pairs, retires one member per clock, and holds every input steady between falling edges. The bench instance narrows the counters to 12 bits, so that the saturation rule can be reached within the run.

// File: rtl/stall_acct_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and counter indexing for the stall accounter.
// Assumes: penalties are small compile-time constants.
package stall_acct_pkg;

    // Cycles lost per source that reads a register still being loaded.
    localparam int unsigned LOAD_PENALTY   = 2;
    // Cycles lost when a control transfer is taken.
    localparam int unsigned BRANCH_PENALTY = 2;
    // Number of source operands examined per instruction.
    localparam int unsigned NUM_SRC        = 2;

    // Position of each running counter in the accumulator bank.
    typedef enum int unsigned {
        CNT_TOTAL   = 0,
        CNT_LOAD    = 1,
        CNT_BRANCH  = 2,
        CNT_TAKEN   = 3,
        CNT_UNTAKEN = 4
    } cnt_sel_e;

    localparam int unsigned NUM_CNT = 5;

endpackage

// File: rtl/hazard_tracker.sv
`timescale 1ns/1ps
// Module: hazard_tracker
// Holds the pending and active load masks and prices the load-use stall
// of the instruction that is retiring now. The stall is combinational and
// uses the active mask as it was before this instruction.
// Assumes: at most one retirement per clock; indices are below NUM_REGS.
module hazard_tracker
    import stall_acct_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned TOT_W    = 11,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ret_valid,
    input  logic                 grp_first,
    input  logic [NUM_SRC-1:0]   src_vld,
    input  logic [IDX_W-1:0]     src_idx [NUM_SRC],
    input  logic                 is_load,
    input  logic [IDX_W-1:0]     load_dst,
    output logic [TOT_W-1:0]     load_stall
);

    logic [NUM_REGS-1:0] pend_q;
    logic [NUM_REGS-1:0] active_q;
    logic [NUM_REGS-1:0] pend_next;
    logic [NUM_SRC-1:0]  hit;

    // Per-source hit detection against the active mask.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign hit[s] = src_vld[s] && active_q[src_idx[s]];
    end

    // Price the hits: a fixed penalty for every matching source.
    always_comb begin
        load_stall = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (hit[s]) begin
                load_stall = load_stall + TOT_W'(LOAD_PENALTY);
            end
        end
    end

    // Pending mask after this instruction: cleared at a group start, then the load bit.
    always_comb begin
        pend_next = grp_first ? '0 : pend_q;
        if (is_load) begin
            pend_next[load_dst] = 1'b1;
        end
    end

    // Promote the pending mask into the active mask at every retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            active_q <= '0;
        end else if (ret_valid) begin
            pend_q   <= pend_next;
            active_q <= pend_next;
        end
    end

endmodule

// File: rtl/group_max.sv
`timescale 1ns/1ps
// Module: group_max
// Tracks the largest instruction cost seen in the current issue group and
// presents the charge for the total counter when the closing member retires.
// Assumes: groups are opened by a first member and not interleaved.
module group_max #(
    parameter int unsigned TOT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_valid,
    input  logic             grp_first,
    input  logic             grp_last,
    input  logic [TOT_W-1:0] instr_total,
    output logic             charge_en,
    output logic [TOT_W-1:0] charge
);

    logic [TOT_W-1:0] run_max_q;
    logic [TOT_W-1:0] prior;

    // Earlier members count only when this member does not open a group.
    assign prior = grp_first ? '0 : run_max_q;

    // Larger of the earlier members and the current one.
    always_comb begin
        charge = (instr_total > prior) ? instr_total : prior;
    end

    // The total counter is charged only by the closing member.
    assign charge_en = ret_valid && grp_last;

    // Remember the running maximum for the next member of the group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_max_q <= '0;
        end else if (ret_valid) begin
            run_max_q <= charge;
        end
    end

endmodule

// File: rtl/sat_accum.sv
`timescale 1ns/1ps
// Module: sat_accum
// One running counter that adds an increment when enabled and clamps at
// its all-ones value instead of wrapping.
// Assumes: INC_W is smaller than CNT_W.
module sat_accum #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned INC_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W:0] sum;

    // Widened sum so that the carry flags an overflow.
    assign sum = {1'b0, count} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};

    // Accumulate with clamping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (en) begin
            count <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/stall_cycle_accounter.sv
`timescale 1ns/1ps
// Module: stall_cycle_accounter (top)
// Prices each retiring instruction (base + load-use stall + taken-branch
// stall), applies the pair-maximum rule to the total cycle counter and
// keeps saturating running counters for stalls and branch outcomes.
// Assumes: at most one retirement per clock; groups are well formed.
module stall_cycle_accounter
    import stall_acct_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned CYC_W    = 8,
    parameter int unsigned CNT_W    = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned TOT_W   = CYC_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_valid,
    input  logic             grp_first,
    input  logic             grp_last,
    input  logic [CYC_W-1:0] base_cycles,
    input  logic             src_a_vld,
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic             src_b_vld,
    input  logic [IDX_W-1:0] src_b_idx,
    input  logic             is_load,
    input  logic [IDX_W-1:0] load_dst,
    input  logic             is_branch,
    input  logic             br_taken,
    output logic [TOT_W-1:0] instr_cycles,
    output logic [CNT_W-1:0] total_cycles,
    output logic [CNT_W-1:0] load_stall_cycles,
    output logic [CNT_W-1:0] branch_stall_cycles,
    output logic [CNT_W-1:0] taken_branches,
    output logic [CNT_W-1:0] untaken_branches
);

    logic [NUM_SRC-1:0] src_vld;
    logic [IDX_W-1:0]   src_idx [NUM_SRC];
    logic [TOT_W-1:0]   load_stall;
    logic [TOT_W-1:0]   branch_stall;
    logic [TOT_W-1:0]   instr_total;
    logic               charge_en;
    logic [TOT_W-1:0]   charge;
    logic               cnt_en  [NUM_CNT];
    logic [TOT_W-1:0]   cnt_inc [NUM_CNT];
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    // Gather the source operands into indexed form.
    assign src_vld    = {src_b_vld, src_a_vld};
    assign src_idx[0] = src_a_idx;
    assign src_idx[1] = src_b_idx;

    hazard_tracker #(
        .NUM_REGS (NUM_REGS),
        .TOT_W    (TOT_W)
    ) u_hazard (
        .clk        (clk),
        .rst_n      (rst_n),
        .ret_valid  (ret_valid),
        .grp_first  (grp_first),
        .src_vld    (src_vld),
        .src_idx    (src_idx),
        .is_load    (is_load),
        .load_dst   (load_dst),
        .load_stall (load_stall)
    );

    // Taken control transfers pay a fixed penalty.
    assign branch_stall = (is_branch && br_taken) ? TOT_W'(BRANCH_PENALTY) : '0;

    // Full cost of the retiring instruction.
    assign instr_total = TOT_W'(base_cycles) + load_stall + branch_stall;

    group_max #(
        .TOT_W (TOT_W)
    ) u_gmax (
        .clk         (clk),
        .rst_n       (rst_n),
        .ret_valid   (ret_valid),
        .grp_first   (grp_first),
        .grp_last    (grp_last),
        .instr_total (instr_total),
        .charge_en   (charge_en),
        .charge      (charge)
    );

    // Route enables and increments to each counter slot.
    always_comb begin
        cnt_en[CNT_TOTAL]    = charge_en;
        cnt_inc[CNT_TOTAL]   = charge;
        cnt_en[CNT_LOAD]     = ret_valid;
        cnt_inc[CNT_LOAD]    = load_stall;
        cnt_en[CNT_BRANCH]   = ret_valid;
        cnt_inc[CNT_BRANCH]  = branch_stall;
        cnt_en[CNT_TAKEN]    = ret_valid && is_branch && br_taken;
        cnt_inc[CNT_TAKEN]   = TOT_W'(1);
        cnt_en[CNT_UNTAKEN]  = ret_valid && is_branch && !br_taken;
        cnt_inc[CNT_UNTAKEN] = TOT_W'(1);
    end

    // Bank of saturating counters, one per statistic.
    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        sat_accum #(
            .CNT_W (CNT_W),
            .INC_W (TOT_W)
        ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cnt_en[c]),
            .inc   (cnt_inc[c]),
            .count (cnt_val[c])
        );
    end

    assign total_cycles        = cnt_val[CNT_TOTAL];
    assign load_stall_cycles   = cnt_val[CNT_LOAD];
    assign branch_stall_cycles = cnt_val[CNT_BRANCH];
    assign taken_branches      = cnt_val[CNT_TAKEN];
    assign untaken_branches    = cnt_val[CNT_UNTAKEN];

    // Register the cost of the instruction that just retired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_cycles <= '0;
        end else if (ret_valid) begin
            instr_cycles <= instr_total;
        end
    end

endmodule

// File: rtl/stall_acct_checker.sv
`timescale 1ns/1ps
// Module: stall_acct_checker
// Temporal checks on the accounter's ports, bound into the top module.
// Assumes: one retirement per clock and well-formed groups.
module stall_acct_checker
    import stall_acct_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned CYC_W    = 8,
    parameter int unsigned CNT_W    = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned TOT_W   = CYC_W + 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ret_valid,
    input logic             grp_last,
    input logic [CYC_W-1:0] base_cycles,
    input logic             is_branch,
    input logic [TOT_W-1:0] instr_cycles,
    input logic [CNT_W-1:0] total_cycles,
    input logic [CNT_W-1:0] load_stall_cycles,
    input logic [CNT_W-1:0] branch_stall_cycles,
    input logic [CNT_W-1:0] taken_branches,
    input logic [CNT_W-1:0] untaken_branches
);

    logic armed_q;
    logic in_rst_q;

    // armed_q: the previous clock was out of reset, so $past is meaningful.
    always_ff @(posedge clk) begin
        armed_q  <= rst_n;
        in_rst_q <= !rst_n;
    end

    // R1: the first clock after reset shows cleared outputs.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_rst_q |-> (total_cycles == '0 && load_stall_cycles == '0 &&
                      branch_stall_cycles == '0 && taken_branches == '0 &&
                      untaken_branches == '0 && instr_cycles == '0));

    // R2: one instruction adds at most one penalty per source.
    assert_load_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (load_stall_cycles - $past(load_stall_cycles))
                    <= CNT_W'(LOAD_PENALTY * NUM_SRC));

    // R4: branch stalls grow in whole penalties or sit at saturation.
    assert_branch_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (branch_stall_cycles == $past(branch_stall_cycles) ||
                     branch_stall_cycles == $past(branch_stall_cycles) + CNT_W'(BRANCH_PENALTY) ||
                     (&branch_stall_cycles)));

    // R4: a non-branch retirement leaves both outcome counters alone.
    assert_nonbranch_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(ret_valid && !is_branch)) |->
            ($stable(taken_branches) && $stable(untaken_branches)));

    // R5: an instruction never costs less than its base cycles.
    assert_cost_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(ret_valid)) |-> instr_cycles >= TOT_W'($past(base_cycles)));

    // R6: the total counter moves only on a closing member.
    assert_total_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(ret_valid && grp_last)) |-> $stable(total_cycles));

    // R9: counters never wrap downwards.
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (total_cycles >= $past(total_cycles) &&
                     load_stall_cycles >= $past(load_stall_cycles) &&
                     taken_branches >= $past(taken_branches) &&
                     untaken_branches >= $past(untaken_branches)));

    // R10: idle clocks change nothing.
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(ret_valid)) |->
            ($stable(load_stall_cycles) && $stable(branch_stall_cycles) &&
             $stable(taken_branches) && $stable(untaken_branches)));

endmodule

bind stall_cycle_accounter stall_acct_checker #(
    .NUM_REGS (NUM_REGS),
    .CYC_W    (CYC_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk                 (clk),
    .rst_n               (rst_n),
    .ret_valid           (ret_valid),
    .grp_last            (grp_last),
    .base_cycles         (base_cycles),
    .is_branch           (is_branch),
    .instr_cycles        (instr_cycles),
    .total_cycles        (total_cycles),
    .load_stall_cycles   (load_stall_cycles),
    .branch_stall_cycles (branch_stall_cycles),
    .taken_branches      (taken_branches),
    .untaken_branches    (untaken_branches)
);

// File: tb/sim_stall_cycle_accounter.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver prices each instruction from the
// requirements and queues the expected outputs; the monitor compares
// them one clock after each retirement.
module sim_stall_cycle_accounter;

    localparam int CYC_W = 8;
    localparam int CNT_W = 12;
    localparam int TOT_W = CYC_W + 3;
    localparam longint CMAX = (64'd1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ret_valid = 1'b0;
    logic             grp_first = 1'b0;
    logic             grp_last = 1'b0;
    logic [CYC_W-1:0] base_cycles = '0;
    logic             src_a_vld = 1'b0;
    logic [3:0]       src_a_idx = '0;
    logic             src_b_vld = 1'b0;
    logic [3:0]       src_b_idx = '0;
    logic             is_load = 1'b0;
    logic [3:0]       load_dst = '0;
    logic             is_branch = 1'b0;
    logic             br_taken = 1'b0;
    logic [TOT_W-1:0] instr_cycles;
    logic [CNT_W-1:0] total_cycles;
    logic [CNT_W-1:0] load_stall_cycles;
    logic [CNT_W-1:0] branch_stall_cycles;
    logic [CNT_W-1:0] taken_branches;
    logic [CNT_W-1:0] untaken_branches;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    stall_cycle_accounter #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid),
        .grp_first(grp_first), .grp_last(grp_last), .base_cycles(base_cycles),
        .src_a_vld(src_a_vld), .src_a_idx(src_a_idx),
        .src_b_vld(src_b_vld), .src_b_idx(src_b_idx),
        .is_load(is_load), .load_dst(load_dst),
        .is_branch(is_branch), .br_taken(br_taken),
        .instr_cycles(instr_cycles), .total_cycles(total_cycles),
        .load_stall_cycles(load_stall_cycles),
        .branch_stall_cycles(branch_stall_cycles),
        .taken_branches(taken_branches), .untaken_branches(untaken_branches)
    );

    typedef struct {
        string  tag;
        longint instr, tot, ls, bs, tk, ut;
    } exp_t;

    exp_t exp_q[$];

    // Reference state
    logic [15:0] m_act, m_pend;
    longint m_max, m_tot, m_ls, m_bs, m_tk, m_ut;

    function automatic longint sat(longint v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic model_reset();
        m_act = '0; m_pend = '0; m_max = 0;
        m_tot = 0; m_ls = 0; m_bs = 0; m_tk = 0; m_ut = 0;
    endtask

    task automatic chk(string what, string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare the counters against the reference right now.
    task automatic check_counters(string tag);
        chk("total", tag, longint'(total_cycles), m_tot);
        chk("load_stall", tag, longint'(load_stall_cycles), m_ls);
        chk("branch_stall", tag, longint'(branch_stall_cycles), m_bs);
        chk("taken", tag, longint'(taken_branches), m_tk);
        chk("untaken", tag, longint'(untaken_branches), m_ut);
    endtask

    // Driver: price the instruction, queue the expectation, drive the pins.
    task automatic retire(string tag, bit first, bit last, int base,
                          bit va, int a, bit vb, int b,
                          bit ld, int dst, bit br, bit tk);
        longint ls, bs, cost, cand;
        exp_t e;
        ls = 0;
        if (va && m_act[a]) ls += 2;
        if (vb && m_act[b]) ls += 2;
        bs = (br && tk) ? 2 : 0;
        cost = base + ls + bs;
        cand = first ? cost : ((cost > m_max) ? cost : m_max);
        m_max = cand;
        if (last) m_tot = sat(m_tot + cand);
        m_ls = sat(m_ls + ls);
        m_bs = sat(m_bs + bs);
        if (br && tk) m_tk = sat(m_tk + 1);
        if (br && !tk) m_ut = sat(m_ut + 1);
        if (first) m_pend = '0;
        if (ld) m_pend[dst] = 1'b1;
        m_act = m_pend;
        e.tag = tag; e.instr = cost; e.tot = m_tot; e.ls = m_ls;
        e.bs = m_bs; e.tk = m_tk; e.ut = m_ut;
        exp_q.push_back(e);
        @(negedge clk);
        ret_valid = 1'b1; grp_first = first; grp_last = last;
        base_cycles = CYC_W'(base);
        src_a_vld = va; src_a_idx = 4'(a); src_b_vld = vb; src_b_idx = 4'(b);
        is_load = ld; load_dst = 4'(dst); is_branch = br; br_taken = tk;
    endtask

    task automatic single(string tag, int base, bit va, int a, bit vb, int b,
                          bit ld, int dst, bit br, bit tk);
        retire(tag, 1'b1, 1'b1, base, va, a, vb, b, ld, dst, br, tk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ret_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        ret_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk("instr_cycles", "R1", longint'(instr_cycles), 0);
        check_counters("R1");
    endtask

    // Monitor: one clock after a retirement, pop and compare.
    initial begin
        forever begin
            @(posedge clk);
            if (ret_valid && rst_n) begin
                exp_t e;
                #2;
                if (exp_q.size() == 0) begin
                    chk("queue", "R5", 0, 1);
                end else begin
                    e = exp_q.pop_front();
                    chk("instr_cycles", e.tag, longint'(instr_cycles), e.instr);
                    chk("total", e.tag, longint'(total_cycles), e.tot);
                    chk("load_stall", e.tag, longint'(load_stall_cycles), e.ls);
                    chk("branch_stall", e.tag, longint'(branch_stall_cycles), e.bs);
                    chk("taken", e.tag, longint'(taken_branches), e.tk);
                    chk("untaken", e.tag, longint'(untaken_branches), e.ut);
                end
            end
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (2) @(negedge clk);
        do_reset();

        // R2: load r3, then read it once; R8: the next reader is clear.
        single("R2", 1, 0, 0, 0, 0, 1, 3, 0, 0);
        single("R2", 1, 1, 3, 0, 0, 0, 0, 0, 0);
        single("R8", 1, 1, 3, 0, 0, 0, 0, 0, 0);
        // R2: both sources on the same loaded register cost 4.
        single("R2", 2, 0, 0, 0, 0, 1, 5, 0, 0);
        single("R2", 2, 1, 5, 1, 5, 0, 0, 0, 0);
        // R3: invalid sources pointing at a loaded register.
        single("R3", 1, 0, 0, 0, 0, 1, 6, 0, 0);
        single("R3", 1, 0, 6, 0, 6, 0, 0, 0, 0);
        // R4: taken, not taken, and no branch.
        single("R4", 1, 0, 0, 0, 0, 0, 0, 1, 1);
        single("R4", 1, 0, 0, 0, 0, 0, 0, 1, 0);
        single("R4", 1, 0, 0, 0, 0, 0, 0, 0, 1);
        // R6/R7: pair, first loads r7, partner stalls but first sets the max.
        retire("R6", 1, 0, 5, 0, 0, 0, 0, 1, 7, 0, 0);
        retire("R7", 0, 1, 1, 1, 7, 0, 0, 0, 0, 0, 0);
        // R6: pair where the last member wins with a taken branch.
        retire("R6", 1, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0);
        retire("R6", 0, 1, 3, 0, 0, 0, 0, 0, 0, 1, 1);
        // R8: load in previous group reaches only the next group's first member.
        single("R8", 1, 0, 0, 0, 0, 1, 9, 0, 0);
        retire("R8", 1, 0, 1, 1, 9, 0, 0, 0, 0, 0, 0);
        retire("R8", 0, 1, 1, 1, 9, 0, 0, 0, 0, 0, 0);
        // R8: the load of a group's first member is seen by the next group's start.
        retire("R8", 1, 0, 1, 0, 0, 0, 0, 1, 4, 0, 0);
        retire("R8", 0, 1, 1, 1, 4, 0, 0, 0, 0, 0, 0);
        single("R8", 1, 0, 0, 1, 4, 0, 0, 0, 0);
        // R10: idle clocks leave everything alone.
        idle(4);
        check_counters("R10");
        // R1: a load before reset must not stall afterwards.
        single("R1", 1, 0, 0, 0, 0, 1, 2, 0, 0);
        idle(1);
        do_reset();
        single("R1", 1, 1, 2, 0, 0, 0, 0, 0, 0);
        // R9: drive the total counter past its all-ones value.
        for (int i = 0; i < 20; i++) begin
            single("R9", 255, 0, 0, 0, 0, 0, 0, 1, 1);
        end
        idle(2);
        check_counters("R9");
        chk("total at ceiling", "R9", longint'(total_cycles), CMAX);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule